// File: doc/BRIEF.md
# Interrupt Flag and Enable Registers

This block gathers seven interrupt sources of an 8-bit register-mapped peripheral into two registers. The sources are two control lines on each of two ports, a shift register and two timers. A flag register latches each source's event. An enable register selects which latched events may raise the shared interrupt request. The request output is active low. Source blocks send one-cycle set pulses and clear pulses. Software reads and writes both registers over a simple register bus.

Reads are combinational from the current register state. Writes take effect at the rising clock edge. The interrupt output follows the registers in the same cycle they change. Writes to the enable register work in set/clear style: bit 7 of the written byte picks the direction. Bit 7 of the flag register is computed and tells software at a glance whether an enabled source is pending.

Top module: `irq_aggregate`

## Requirements
- R1: The flag register is at offset 0xD and the enable register at offset 0xE. Every other offset reads as 0x00, and a write there changes neither register.
- R2: Bit positions in both registers are: bit 0 port A control line 2, bit 1 port A control line 1, bit 2 shift register, bit 3 port B control line 2, bit 4 port B control line 1, bit 5 timer 2, bit 6 timer 1. A set pulse on `srcSet[i]` sets flag bit i at the next rising edge.
- R3: Flag register bit 7 reads 1 exactly when some flag bit and its matching enable bit are both 1.
- R4: A write to the enable register with data bit 7 = 1 sets each enable bit whose data bit is 1. Other enable bits keep their values.
- R5: A write to the enable register with data bit 7 = 0 clears each enable bit whose data bit is 1. Other enable bits keep their values.
- R6: Enable register bit 7 always reads 0.
- R7: `irqN` is 0 exactly when some flag bit and its enable bit are both 1. It follows the register state within the same cycle.
- R8: Writing 1 to a flag register bit clears that flag, and writing 0 leaves it unchanged. A pulse on `srcClr[i]` also clears flag bit i.
- R9: If a set pulse arrives for a flag in the same cycle as a clear pulse or a clearing write for that flag, the flag ends up set.
- R10: Reset (active-low `rstN`) clears all flags and enables, so `irqN` is 1 and both registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset for reads and writes |
| busWrEn | input | 1 | Write strobe, sampled at the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| srcSet | input | 7 | Per-source set pulses |
| srcClr | input | 7 | Per-source clear pulses |
| irqN | output | 1 | Active-low interrupt request |

## Verification
Some properties are checked on every cycle. Flag bit 7 on the read port must always agree with the request pin, and enable bit 7 must always read 0. Each set pulse must show up as a set flag one cycle later, even when a clear competes with it. Set-mode enable writes and clearing flag writes must take effect at the next edge. Reset must hold the request deasserted. Other behaviours need the bench's sweeps over all 128 enable patterns in both write modes, with varied flag patterns. These cover exact register contents, the unchanged bits, the decoding of unused offsets and the request level against a modelled mask.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef struct packed {
    logic wrFlag;
    logic wrEnable;
    logic rdFlag;
    logic rdEnable;
  } irqStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 4'hE
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output irqStrobes_t       strb
);
  logic hitFlag;
  logic hitEnable;

  assign hitFlag   = (busAddr == FLAG_ADDR);
  assign hitEnable = (busAddr == ENABLE_ADDR);

  always_comb begin
    strb          = '0;
    strb.rdFlag   = hitFlag;
    strb.rdEnable = hitEnable;
    strb.wrFlag   = hitFlag & busWrEn;
    strb.wrEnable = hitEnable & busWrEn;
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strb,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic               irqN
);
  localparam int MODE_BIT = DATA_W - 1;

  logic [NUM_SRC-1:0] wrMask;
  logic               pending;

  assign wrMask = busWrData[NUM_SRC-1:0];

  // One flag cell per source: a set pulse beats any clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic clrHit;
    assign clrHit = srcClr[i] | (strb.wrFlag & wrMask[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flagQ[i] <= 1'b0;
      else if (srcSet[i]) flagQ[i] <= 1'b1;
      else if (clrHit)    flagQ[i] <= 1'b0;
    end
  end

  // Enable register: the mode bit chooses set or clear for the written ones.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
    end else if (strb.wrEnable) begin
      if (busWrData[MODE_BIT]) enableQ <= enableQ | wrMask;
      else                     enableQ <= enableQ & ~wrMask;
    end
  end

  assign pending = |(flagQ & enableQ);
  assign irqN    = ~pending;

  always_comb begin
    busRdData = '0;
    if (strb.rdFlag) begin
      busRdData[NUM_SRC-1:0] = flagQ;
      busRdData[MODE_BIT]    = pending;
    end else if (strb.rdEnable) begin
      busRdData[NUM_SRC-1:0] = enableQ;
    end
  end
endmodule

// File: rtl/irq_aggregate.sv
module irq_aggregate
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 4'hE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  output logic               irqN
);
  irqStrobes_t        strb;
  logic [NUM_SRC-1:0] flagView;
  logic [NUM_SRC-1:0] enableView;

  irq_agg_ctrl #(
    .ADDR_W(ADDR_W),
    .FLAG_ADDR(FLAG_ADDR),
    .ENABLE_ADDR(ENABLE_ADDR)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strb(strb)
  );

  irq_agg_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .busWrData(busWrData),
    .srcSet(srcSet),
    .srcClr(srcClr),
    .busRdData(busRdData),
    .flagQ(flagView),
    .enableQ(enableView),
    .irqN(irqN)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_SRC = 7,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 4'hE
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [DATA_W-1:0]  busWrData,
  input logic [DATA_W-1:0]  busRdData,
  input logic [NUM_SRC-1:0] srcSet,
  input logic [NUM_SRC-1:0] srcClr,
  input logic [NUM_SRC-1:0] flagQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic               irqN
);
  localparam int MODE_BIT = DATA_W - 1;

  // R3 / R7: summary bit on the read port agrees with the request pin
  a_r3_summary_matches_pin: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == FLAG_ADDR) |-> (busRdData[MODE_BIT] == !irqN));

  // R6: enable bit 7 reads zero
  a_r6_enable_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ENABLE_ADDR) |-> (busRdData[MODE_BIT] == 1'b0));

  // R2 / R9: a set pulse always lands, whatever clears compete
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|srcSet) |=> ((flagQ & $past(srcSet)) == $past(srcSet)));

  // R4: set-mode enable write turns on the written bits
  a_r4_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ENABLE_ADDR && busWrData[MODE_BIT])
    |=> ((enableQ & $past(busWrData[NUM_SRC-1:0])) == $past(busWrData[NUM_SRC-1:0])));

  // R5: clear-mode enable write turns off the written bits
  a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ENABLE_ADDR && !busWrData[MODE_BIT])
    |=> ((enableQ & $past(busWrData[NUM_SRC-1:0])) == '0));

  // R8: written ones clear their flags unless a set pulse competes
  a_r8_flag_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == FLAG_ADDR)
    |=> ((flagQ & $past(busWrData[NUM_SRC-1:0] & ~srcSet)) == '0));

  // R10: request is idle while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      a_r10_reset_idle: assert (irqN == 1'b1 && flagQ == '0 && enableQ == '0);
    end
  end
endmodule

bind irq_aggregate irq_agg_checker #(
  .NUM_SRC(NUM_SRC),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .FLAG_ADDR(FLAG_ADDR),
  .ENABLE_ADDR(ENABLE_ADDR)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .busAddr(busAddr),
  .busWrEn(busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .srcSet(srcSet),
  .srcClr(srcClr),
  .flagQ(flagView),
  .enableQ(enableView),
  .irqN(irqN)
);

// File: tb/tb_irq_aggregate.sv
module tb_irq_aggregate;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_FLAG = 4'hD;
  localparam logic [3:0] A_EN   = 4'hE;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] busAddr;
  logic       busWrEn;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic [6:0] srcSet;
  logic [6:0] srcClr;
  logic       irqN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [6:0] flagM = '0;
  logic [6:0] enM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregate dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .srcSet(srcSet),
    .srcClr(srcClr), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic readChk(input logic [3:0] a, input logic [7:0] exp, input string req);
    busAddr = a;
    #1;
    chk(req, busRdData, exp);
  endtask

  function automatic logic [7:0] expFlagRd();
    return {|(flagM & enM), flagM};
  endfunction

  task automatic irqChk(input string req);
    chk(req, {7'b0, irqN}, {7'b0, ~|(flagM & enM)});
  endtask

  task automatic cycle(input logic wr, input logic [3:0] a, input logic [7:0] d,
                       input logic [6:0] s, input logic [6:0] c);
    logic [6:0] wclr;
    busWrEn = wr; busAddr = a; busWrData = d; srcSet = s; srcClr = c;
    @(posedge clk);
    wclr  = (wr && a == A_FLAG) ? d[6:0] : 7'h00;
    flagM = (flagM & ~c & ~wclr) | s;
    if (wr && a == A_EN) enM = d[7] ? (enM | d[6:0]) : (enM & ~d[6:0]);
    #1;
    busWrEn = 1'b0; srcSet = '0; srcClr = '0;
  endtask

  initial begin
    rstN = 1'b0; busAddr = '0; busWrEn = 1'b0; busWrData = '0; srcSet = '0; srcClr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    readChk(A_FLAG, 8'h00, "R10 flag after reset");
    readChk(A_EN, 8'h00, "R10 enable after reset");
    irqChk("R10 irq idle after reset");
    rstN = 1'b1;

    // R2: walk each source bit
    cycle(1'b1, A_EN, 8'hFF, '0, '0);
    for (int i = 0; i < 7; i++) begin
      cycle(1'b0, A_FLAG, 8'h00, 7'(1 << i), '0);
      readChk(A_FLAG, expFlagRd(), "R2 single source sets its bit");
      chk("R2 bit position", busRdData, {1'b1, 7'(1 << i)});
      cycle(1'b1, A_FLAG, 8'h7F, '0, '0);
    end

    // R1: other offsets read zero and writes there are ignored
    cycle(1'b0, A_FLAG, 8'h00, 7'h55, '0);
    for (int a = 0; a < 16; a++) begin
      if (a != A_FLAG && a != A_EN) begin
        readChk(4'(a), 8'h00, "R1 unused offset reads zero");
        cycle(1'b1, 4'(a), 8'h7F, '0, '0);
        cycle(1'b1, 4'(a), 8'hFF, '0, '0);
      end
    end
    readChk(A_FLAG, {1'b1, 7'h55}, "R1 flags untouched by other offsets");
    readChk(A_EN, 8'h7F, "R1 enables untouched by other offsets");

    // R8: flag write semantics and clear pulses
    cycle(1'b0, A_FLAG, 8'h00, 7'h7F, '0);
    cycle(1'b1, A_FLAG, 8'h00, '0, '0);
    readChk(A_FLAG, 8'hFF, "R8 writing zeros keeps flags");
    cycle(1'b1, A_FLAG, 8'h05, '0, '0);
    readChk(A_FLAG, 8'hFA, "R8 writing ones clears flags");
    cycle(1'b0, A_FLAG, 8'h00, '0, 7'h10);
    readChk(A_FLAG, 8'hEA, "R8 clear pulse clears flag");
    cycle(1'b1, A_FLAG, 8'h7F, '0, '0);
    readChk(A_FLAG, 8'h00, "R8 all flags cleared");

    // R9: set wins against clear pulse and clearing write
    cycle(1'b0, A_FLAG, 8'h00, 7'h21, 7'h21);
    readChk(A_FLAG, {1'b1, 7'h21}, "R9 set beats clear pulse");
    cycle(1'b1, A_FLAG, 8'h7F, 7'h40, '0);
    readChk(A_FLAG, {1'b1, 7'h40}, "R9 set beats clearing write");
    cycle(1'b1, A_FLAG, 8'h7F, '0, '0);

    // R4, R6, R3, R7: sweep every enable pattern in set mode
    for (int e = 0; e < 128; e++) begin
      logic [6:0] f;
      f = 7'((e * 5 + 3) & 8'h7F);
      cycle(1'b1, A_EN, 8'h7F, '0, '0);
      cycle(1'b1, A_EN, {1'b1, 7'(e)}, '0, '0);
      readChk(A_EN, {1'b0, 7'(e)}, "R4 R6 enable set mode");
      cycle(1'b0, A_FLAG, 8'h00, f, '0);
      readChk(A_FLAG, expFlagRd(), "R3 summary bit");
      irqChk("R7 irq level");
      cycle(1'b1, A_FLAG, 8'h7F, '0, '0);
      irqChk("R8 irq after clearing flags");
    end

    // R5: sweep every pattern in clear mode
    for (int e = 0; e < 128; e++) begin
      cycle(1'b1, A_EN, 8'hFF, '0, '0);
      cycle(1'b1, A_EN, {1'b0, 7'(e)}, '0, '0);
      readChk(A_EN, {1'b0, 7'h7F & ~7'(e)}, "R5 enable clear mode");
    end

    // R7: request follows register state in the cycle of change
    cycle(1'b1, A_EN, 8'h7F, '0, '0);
    cycle(1'b1, A_EN, 8'hA0, '0, '0);
    cycle(1'b0, A_FLAG, 8'h00, 7'h20, '0);
    chk("R7 irq low right after flag set", {7'b0, irqN}, 8'h00);
    cycle(1'b1, A_EN, 8'h20, '0, '0);
    chk("R7 irq high right after enable cleared", {7'b0, irqN}, 8'h01);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule